// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction per clock edge. Each cycle it fetches a word from its own instruction store, decodes it, reads two operands from a 32-entry register file, runs the ALU, and accesses its own data store. On that same edge it commits the register result and any memory write, and it steps the program counter. The supported set is seven register-to-register operations (add, sub, and, or, xor, nor, signed set-less-than), word load and store, branch-if-equal and an absolute jump.

Decoding takes two levels. The opcode is first sorted into an instruction class: ALU, LOAD, STORE, BRANCH, JUMP or NOP. A unique case on that class drives the main control word. A second decoder then turns the 2-bit ALU request, plus the funct field when the request defers to it, into a 4-bit ALU operation code. In that code bit 3 selects the subtract path and bits 1:0 pick the logic function. There is no state machine: the only sequential state is the PC, the register file and the two stores.

Both stores can be written through a load port while reset is held. A peek port reads the data store without a clock. The PC is visible on an output, so a host can place a program and data and then inspect the results.

Top module: `sc_core`

## Requirements
- R1: Synchronous active-high reset. While `rst` is high, every rising edge sets the PC to 0 and clears all 32 registers. During reset the core performs no data-store write of its own.
- R2: When `ld_en` is high, a rising edge writes `ld_data` to word `ld_idx`. The target is the data store if `ld_dmem`=1 and the instruction store if `ld_dmem`=0. `pk_data` shows data-store word `pk_idx` combinationally. Stores are indexed by byte address bits above bit 1.
- R3: Field positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], 16-bit offset [15:0], jump field [25:0]. A load writes rt, and an R-type writes rd. Loads and stores use rs as the base, and the offset is sign-extended, so negative offsets work.
- R4: With opcode 000000, the funct value picks the operation: 100000 add, 100010 sub, 100100 and, 100101 or, 100110 xor, 100111 nor, 101010 signed set-less-than (result 1 or 0). The result goes to rd.
- R5: Opcode 100011 loads the word at rs+offset into rt. Opcode 101011 stores rt to rs+offset. A load leaves memory unchanged.
- R6: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. When they differ, it is PC+4.
- R7: Opcode 000010 sets the next PC to PC+4 bits [31:28], followed by instruction bits [25:0], followed by 00.
- R8: Register 0 always reads as zero, and a write that targets it has no effect.
- R9: Any other opcode changes no register and no memory, and only advances the PC by 4.
- R10: Without a taken branch or a jump, the PC advances by 4 each cycle. The PC stays word-aligned.
- R11: In any cycle, at most one of register write, memory write, branch and jump is active. Loads and stores always use the ALU add operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store-load write strobe |
| ld_dmem | input | 1 | Load target: 1 data store, 0 instruction store |
| ld_idx | input | LAW | Word index for the load write |
| ld_data | input | 32 | Word written by the load port |
| pk_idx | input | DAW | Data-store word index to observe |
| pk_data | output | 32 | Data-store word at `pk_idx` |
| pc_o | output | 32 | Current program counter |

## Verification
Several behaviours are checked on every cycle by assertions:
- the PC steps by 4 after any cycle without a taken branch or a jump;
- a taken branch lands on its computed target;
- a jump lands on the spliced address;
- the PC stays aligned;
- the control word is exclusive;
- memory instructions always get the add operation.

Other behaviours only show up in the bench's program run, through the stored results read back on the peek port. These are the functional values of each ALU operation, sign extension of a negative offset, the rt-versus-rd destination choice, the dropped write to register 0, and the no-op treatment of an unknown opcode.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_ALU    = 6'b000000;
    localparam logic [5:0] OPC_LOAD   = 6'b100011;
    localparam logic [5:0] OPC_STORE  = 6'b101011;
    localparam logic [5:0] OPC_BRANCH = 6'b000100;
    localparam logic [5:0] OPC_JUMP   = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_XOR = 6'b100110;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        IC_ALU, IC_LOAD, IC_STORE, IC_BRANCH, IC_JUMP, IC_NOP
    } iclass_e;

    typedef enum logic [1:0] {
        AREQ_ADD   = 2'b00,
        AREQ_SUB   = 2'b01,
        AREQ_FUNCT = 2'b10
    } areq_e;

    // bit 3 selects subtract path, bits 1:0 select the logic function
    typedef enum logic [3:0] {
        AOP_AND = 4'b0000,
        AOP_OR  = 4'b0001,
        AOP_XOR = 4'b0010,
        AOP_NOR = 4'b0011,
        AOP_ADD = 4'b0110,
        AOP_SUB = 4'b1110,
        AOP_SLT = 4'b1111
    } aop_e;

    typedef struct packed {
        logic  dst_rd;
        logic  b_imm;
        logic  wb_mem;
        logic  rf_we;
        logic  mem_rd;
        logic  mem_we;
        logic  branch;
        areq_e areq;
        logic  jump;
    } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    iclass_e cls;

    always_comb begin
        unique case (opcode)
            OPC_ALU:    cls = IC_ALU;
            OPC_LOAD:   cls = IC_LOAD;
            OPC_STORE:  cls = IC_STORE;
            OPC_BRANCH: cls = IC_BRANCH;
            OPC_JUMP:   cls = IC_JUMP;
            default:    cls = IC_NOP;
        endcase
    end

    always_comb begin
        ctrl = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, rf_we: 1'b0,
                 mem_rd: 1'b0, mem_we: 1'b0, branch: 1'b0,
                 areq: AREQ_ADD, jump: 1'b0};
        unique case (cls)
            IC_ALU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.areq   = AREQ_FUNCT;
            end
            IC_LOAD: begin
                ctrl.b_imm  = 1'b1;
                ctrl.wb_mem = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.mem_rd = 1'b1;
            end
            IC_STORE: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_we = 1'b1;
            end
            IC_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.areq   = AREQ_SUB;
            end
            IC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            IC_NOP: begin
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  areq_e      areq,
    input  logic [5:0] funct,
    output aop_e       aop
);

    always_comb begin
        unique case (areq)
            AREQ_ADD: aop = AOP_ADD;
            AREQ_SUB: aop = AOP_SUB;
            AREQ_FUNCT: begin
                unique case (funct)
                    FN_ADD:  aop = AOP_ADD;
                    FN_SUB:  aop = AOP_SUB;
                    FN_AND:  aop = AOP_AND;
                    FN_OR:   aop = AOP_OR;
                    FN_XOR:  aop = AOP_XOR;
                    FN_NOR:  aop = AOP_NOR;
                    FN_SLT:  aop = AOP_SLT;
                    default: aop = AOP_ADD;
                endcase
            end
            default: aop = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aop_e         aop,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         lt;

    assign b_eff = aop[3] ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, aop[3]};
    assign lt    = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];

    always_comb begin
        unique case (aop)
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_XOR: y = a ^ b;
            AOP_NOR: y = ~(a | b);
            AOP_ADD: y = sum;
            AOP_SUB: y = sum;
            AOP_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = sum;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W       = 32,
    parameter int NREGS   = 32,
    localparam int RAW    = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [W-1:0]   rd1,
    output logic [W-1:0]   rd2,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [W-1:0]   wd
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_wmem.sv
module sc_wmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int  IMEM_DEPTH = 64,
    parameter int  DMEM_DEPTH = 64,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_en,
    input  logic           ld_dmem,
    input  logic [LAW-1:0] ld_idx,
    input  logic [31:0]    ld_data,
    input  logic [DAW-1:0] pk_idx,
    output logic [31:0]    pk_data,
    output logic [31:0]    pc_o
);

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_ext;
    logic [31:0] rs_val, rt_val, alu_b, alu_y, wb_val;
    logic        alu_zero, take_br;
    logic [4:0]  wr_reg;
    ctrl_t       ctrl;
    aop_e        aop;

    logic [0:0][IAW-1:0] im_ra;
    logic [0:0][31:0]    im_rd;
    logic [1:0][DAW-1:0] dm_ra;
    logic [1:0][31:0]    dm_rd;
    logic                im_we, dm_we, ld_to_dm;
    logic [DAW-1:0]      dm_wa;
    logic [31:0]         dm_wd;

    // instruction store
    assign im_we    = ld_en && !ld_dmem;
    assign im_ra[0] = pc_q[IAW+1:2];
    assign instr    = im_rd[0];

    sc_wmem #(.W(32), .DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
        .clk(clk), .we(im_we), .waddr(ld_idx[IAW-1:0]), .wdata(ld_data),
        .raddr(im_ra), .rdata(im_rd)
    );

    // decode
    sc_main_ctrl u_mctl (.opcode(instr[31:26]), .ctrl(ctrl));
    sc_alu_ctrl  u_actl (.areq(ctrl.areq), .funct(instr[5:0]), .aop(aop));

    assign imm_ext = {{16{instr[15]}}, instr[15:0]};
    assign wr_reg  = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.W(32), .NREGS(32)) u_rf (
        .clk(clk), .rst(rst),
        .ra1(instr[25:21]), .ra2(instr[20:16]),
        .rd1(rs_val), .rd2(rt_val),
        .we(ctrl.rf_we), .wa(wr_reg), .wd(wb_val)
    );

    // execute
    assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .a(rs_val), .b(alu_b), .aop(aop), .y(alu_y), .zero(alu_zero)
    );

    // data store: load port wins, core writes blocked in reset
    assign ld_to_dm = ld_en && ld_dmem;
    assign dm_we    = ld_to_dm || (ctrl.mem_we && !rst);
    assign dm_wa    = ld_to_dm ? ld_idx[DAW-1:0] : alu_y[DAW+1:2];
    assign dm_wd    = ld_to_dm ? ld_data : rt_val;
    assign dm_ra[0] = alu_y[DAW+1:2];
    assign dm_ra[1] = pk_idx;

    sc_wmem #(.W(32), .DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
        .clk(clk), .we(dm_we), .waddr(dm_wa), .wdata(dm_wd),
        .raddr(dm_ra), .rdata(dm_rd)
    );

    assign pk_data = dm_rd[1];
    assign wb_val  = ctrl.wb_mem ? dm_rd[0] : alu_y;

    // next PC
    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br    = ctrl.branch && alu_zero;

    always_comb begin
        if (ctrl.jump)   pc_next = jmp_target;
        else if (take_br) pc_next = br_target;
        else             pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !take_br) |=> (pc_q == $past(pc_q) + 32'd4));

    // R10
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);

    // R6
    br_target_chk: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(br_target)));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

    // R11
    ctrl_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({ctrl.rf_we && !ctrl.wb_mem, ctrl.mem_we, ctrl.branch, ctrl.jump}) <= 1);

    // R11
    memop_add_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_rd || ctrl.mem_we) |-> (aop == AOP_ADD));

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    localparam int DAW = 6;
    localparam int LAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_en = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [LAW-1:0] ld_idx = '0;
    logic [31:0]    ld_data = '0;
    logic [DAW-1:0] pk_idx = '0;
    logic [31:0]    pk_data;
    logic [31:0]    pc_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sc_core u_sc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_idx(ld_idx), .ld_data(ld_data), .pk_idx(pk_idx),
        .pk_data(pk_data), .pc_o(pc_o)
    );

    // expected data-store words after the program halts
    localparam int NCHK = 15;
    localparam logic [5:0]  EXP_IDX [NCHK] = '{
        6'd0,  6'd1,  6'd16, 6'd17, 6'd18, 6'd19, 6'd20, 6'd21,
        6'd22, 6'd23, 6'd24, 6'd25, 6'd26, 6'd27, 6'd2};
    localparam logic [31:0] EXP_VAL [NCHK] = '{
        32'hF0F0_00FF,   // R3 negative offset from rs base
        32'h0000_0003,   // R5 loads leave memory intact
        32'h0000_0008,   // R4 add
        32'hFFFF_FFFE,   // R4 sub
        32'h0000_000F,   // R4 and
        32'hFFFF_0FFF,   // R4 or
        32'hFFFF_0FF0,   // R4 xor
        32'h0000_F000,   // R4 nor
        32'h0000_0001,   // R4 slt true
        32'h0000_0000,   // R4 slt false
        32'h0000_0000,   // R8 write to r0 dropped
        32'h0000_0000,   // R9 unknown opcode wrote nothing
        32'hDEAD_0001,   // R6 taken branch skipped store
        32'hDEAD_0002,   // R7 jump skipped store
        32'hF0F0_00FF};  // R2 preloaded word readable
    localparam int EXP_REQ [NCHK] = '{3, 5, 4, 4, 4, 4, 4, 4, 4, 4, 8, 9, 6, 7, 2};

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    task automatic put(input bit to_dm, input int idx, input logic [31:0] w);
        ld_en   = 1'b1;
        ld_dmem = to_dm;
        ld_idx  = idx[LAW-1:0];
        ld_data = w;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 pc in reset", pc_o, 32'h0);

        // R2 data preload
        put(1, 0, 32'h0000_0005);
        put(1, 1, 32'h0000_0003);
        put(1, 2, 32'hF0F0_00FF);
        put(1, 3, 32'h0F0F_0F0F);
        put(1, 24, 32'hDEAD_0004);
        put(1, 25, 32'hDEAD_0003);
        put(1, 26, 32'hDEAD_0001);
        put(1, 27, 32'hDEAD_0002);

        // program
        put(0, 0,  enc_i(6'b100011, 0, 1, 16'd0));
        put(0, 1,  enc_i(6'b100011, 0, 2, 16'd4));
        put(0, 2,  enc_i(6'b100011, 0, 3, 16'd8));
        put(0, 3,  enc_i(6'b100011, 0, 4, 16'd12));
        put(0, 4,  enc_r(1, 2, 5, 6'b100000));
        put(0, 5,  enc_r(2, 1, 6, 6'b100010));
        put(0, 6,  enc_r(3, 4, 7, 6'b100100));
        put(0, 7,  enc_r(3, 4, 8, 6'b100101));
        put(0, 8,  enc_r(3, 4, 9, 6'b100110));
        put(0, 9,  enc_r(3, 4, 10, 6'b100111));
        put(0, 10, enc_r(6, 1, 11, 6'b101010));
        put(0, 11, enc_r(1, 6, 12, 6'b101010));
        put(0, 12, enc_r(1, 2, 0, 6'b100000));
        for (int k = 0; k < 8; k++)
            put(0, 13 + k, enc_i(6'b101011, 0, 5 + k, 16'(64 + 4 * k)));
        put(0, 21, enc_i(6'b101011, 0, 0, 16'd96));
        put(0, 22, enc_i(6'b000100, 1, 2, 16'd5));
        put(0, 23, enc_i(6'b001000, 0, 13, 16'd99));
        put(0, 24, enc_i(6'b101011, 0, 13, 16'd100));
        put(0, 25, enc_i(6'b000100, 1, 1, 16'd2));
        put(0, 26, enc_i(6'b101011, 0, 1, 16'd104));
        put(0, 27, enc_i(6'b101011, 0, 1, 16'd104));
        put(0, 28, enc_j(26'd31));
        put(0, 29, enc_i(6'b101011, 0, 2, 16'd108));
        put(0, 30, enc_i(6'b101011, 0, 2, 16'd108));
        put(0, 31, enc_i(6'b101011, 5, 3, 16'hFFF8));
        put(0, 32, enc_i(6'b000100, 0, 0, 16'hFFFF));

        // R1 pc still zero, R2 peek of preloaded word
        check("R1 pc after loads", pc_o, 32'h0);
        pk_idx = 6'd3;
        #0.1;
        check("R2 peek preload", pk_data, 32'h0F0F_0F0F);

        rst = 1'b0;
        @(negedge clk);
        // R10 first step
        check("R10 pc after one cycle", pc_o, 32'h4);

        repeat (60) @(negedge clk);
        // R6 backward branch loop holds the pc
        check("R6 halt loop pc", pc_o, 32'd128);

        for (int i = 0; i < NCHK; i++) begin
            pk_idx = EXP_IDX[i];
            #0.1;
            check($sformatf("R%0d word %0d", EXP_REQ[i], EXP_IDX[i]), pk_data, EXP_VAL[i]);
        end

        // R1 reset again clears pc
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc re-reset", pc_o, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule